// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog Reset

This block is a free-running operating-system timer. A single up-counter advances by one on every clock and wraps from all-ones back to zero. Four compare registers watch it. When the counter holds exactly the value in a compare register, the sticky status flag of that channel is set. The flag can drive a level interrupt output through a per-channel enable. Software reaches every register through a simple word-wide register bus: one select strobe, one write strobe and a word index.

The highest channel can also act as a watchdog. Once software sets the watchdog arm bit, a compare hit on that channel produces a one-cycle reset request. Software cannot clear the arm bit. Only a hardware reset clears it.

Register map (word index, byte offset = 4 × index):

| Index | Byte offset | Contents |
|-------|-------------|----------|
| 0 to 3 | 0x00 to 0x0C | compare value of channel 0 to 3 |
| 4 | 0x10 | counter |
| 5 | 0x14 | status flags, bits 3:0 |
| 6 | 0x18 | watchdog arm, bit 0 |
| 7 | 0x1C | interrupt enables, bits 3:0 |
| 8 to 15 | 0x20 to 0x3C | unused |

Top module: `match_timer_wdog`

## Requirements
- R1: A read request (bus_sel=1, bus_wr=0) at word index i returns on bus_rdata, at the clock edge that ends the request cycle, the register value held during that cycle. The map is: compare 0..3 at index 0..3, counter at 4, status in bits 3:0 at 5, watchdog arm in bit 0 at 6, and interrupt enables in bits 3:0 at 7. All other bits read as zero.
- R2: The counter adds one on every clock that does not load it, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to index 4 loads the write data into the counter in place of that cycle's increment.
- R4: A compare hit occurs only in a cycle where the counter equals compare register n exactly. Status bit n is set at the end of that cycle. A compare value the counter has already passed gives no hit until the counter wraps back to it.
- R5: Writing a 1 to bit n at index 5 clears status bit n, and writing a 0 leaves it unchanged. If a hit and a clear of the same bit fall in one cycle, the bit ends up set.
- R6: irq_o[n] is high exactly while status bit n and enable bit n are both set. Clearing an enable bit does not clear the status bit.
- R7: Writing 1 to bit 0 at index 6 arms the watchdog. Writing 0 leaves it armed.
- R8: wdog_rst_o is high for the one cycle that follows each channel-3 hit that occurs while the watchdog is armed, and is low otherwise.
- R9: A synchronous reset clears the counter, all compare registers, the status flags, the enables, the watchdog arm bit, bus_rdata and all outputs.
- R10: Reads of indices 8 to 15 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | timer and bus clock |
| rst | input | 1 | synchronous active-high reset |
| bus_sel | input | 1 | access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 4 | word index of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered |
| irq_o | output | 4 | per-channel level interrupts |
| wdog_rst_o | output | 1 | one-cycle watchdog reset request |

## Verification
Every result of this block is due one clock edge after its cause:
- read data is due at the edge that ends the read cycle;
- a status flag, and with it the interrupt, is due at the edge that ends the cycle in which the counter equals the compare value;
- the watchdog pulse is due in the cycle that follows the channel-3 hit.

The bench drives its inputs on the falling edge. It advances a cycle-accurate reference model on the rising edge, using the same inputs. It compares the outputs on the next falling edge, so each comparison falls in the cycle where the result is due. Directed sequences wait on the model's counter value rather than on fixed delays. This places a clear and a hit in the same cycle, and a compare value just ahead of or just behind the counter.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

  // Word-index layout: compare registers occupy 0..NUM_CH-1, and the
  // remaining registers follow immediately after them.
  localparam int unsigned OFS_CNT  = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_WEN  = 2;
  localparam int unsigned OFS_IEN  = 3;
  localparam int unsigned NUM_MISC = 4;

endpackage

// File: rtl/mtw_counter.sv
module mtw_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  // R2: free-running increment with natural wrap
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (cnt_q == $past(cnt_q) + ONE));

  // R3: a load replaces the increment
  a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/mtw_channel.sv
module mtw_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              cmp_we_i,
  input  logic [DATA_W-1:0] cmp_val_i,
  input  logic              clr_i,
  input  logic              ien_we_i,
  input  logic              ien_val_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              hit_o,
  output logic              stat_o,
  output logic              ien_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] cmp_q;
  logic              stat_q;
  logic              ien_q;
  logic              irq_q;
  logic              stat_d;
  logic              ien_d;

  assign hit_o  = (cnt_i == cmp_q);
  // A hit wins over a clear in the same cycle.
  assign stat_d = hit_o | (stat_q & ~clr_i);
  assign ien_d  = ien_we_i ? ien_val_i : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      stat_q <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_val_i;
      stat_q <= stat_d;
      ien_q  <= ien_d;
      irq_q  <= stat_d & ien_d;
    end
  end

  assign cmp_o  = cmp_q;
  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign irq_o  = irq_q;

  // R4: an exact match sets the flag at the end of the cycle
  a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> stat_q);

  // R5: a clear without a competing hit drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit_o) |=> !stat_q);

  // R5: without a clear the flag is sticky
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && stat_q) |=> stat_q);

  // R6: the interrupt needs both the flag and the enable
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (stat_q && ien_q));

  // R6: the interrupt is a level while both are set
  a_r6_irq_level: assert property (@(posedge clk) disable iff (rst)
    (stat_q && ien_q) |-> irq_o);

endmodule

// File: rtl/mtw_watchdog.sv
module mtw_watchdog (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic hit_i,
  output logic armed_o,
  output logic pulse_o
);

  logic armed_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_q | arm_i;
      pulse_q <= armed_q & hit_i;
    end
  end

  assign armed_o = armed_q;
  assign pulse_o = pulse_q;

  // R7: software cannot disarm
  a_r7_arm_sticky: assert property (@(posedge clk) disable iff (rst)
    armed_q |=> armed_q);

  // R8: an armed hit fires the reset request
  a_r8_fire_on_hit: assert property (@(posedge clk) disable iff (rst)
    (armed_q && hit_i) |=> pulse_q);

  // R8: the request only follows an armed hit
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(armed_q && hit_i));

endmodule

// File: rtl/match_timer_wdog.sv
module match_timer_wdog #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WADDR_W = 4,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned WDOG_CH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [WADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0]  irq_o,
  output logic               wdog_rst_o
);

  import mtw_pkg::*;

  localparam logic [WADDR_W-1:0] IDX_CNT  = WADDR_W'(NUM_CH + OFS_CNT);
  localparam logic [WADDR_W-1:0] IDX_STAT = WADDR_W'(NUM_CH + OFS_STAT);
  localparam logic [WADDR_W-1:0] IDX_WEN  = WADDR_W'(NUM_CH + OFS_WEN);
  localparam logic [WADDR_W-1:0] IDX_IEN  = WADDR_W'(NUM_CH + OFS_IEN);
  localparam logic [WADDR_W-1:0] IDX_LAST = WADDR_W'(NUM_CH + NUM_MISC - 1);

  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] cnt;
  logic              cnt_load;
  logic              stat_wr;
  logic              ien_wr;
  logic [NUM_CH-1:0] hit_v;
  logic [NUM_CH-1:0] stat_v;
  logic [NUM_CH-1:0] ien_v;
  logic [NUM_CH-1:0] irq_v;
  logic [DATA_W-1:0] cmp_v [NUM_CH];
  logic              wdog_armed;
  logic              wdog_pulse;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign cnt_load = wr_en && (bus_waddr == IDX_CNT);
  assign stat_wr  = wr_en && (bus_waddr == IDX_STAT);
  assign ien_wr   = wr_en && (bus_waddr == IDX_IEN);

  mtw_counter #(.DATA_W(DATA_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_load),
    .load_val_i (bus_wdata),
    .cnt_o      (cnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mtw_channel #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .cnt_i     (cnt),
      .cmp_we_i  (wr_en && (bus_waddr == WADDR_W'(g))),
      .cmp_val_i (bus_wdata),
      .clr_i     (stat_wr & bus_wdata[g]),
      .ien_we_i  (ien_wr),
      .ien_val_i (bus_wdata[g]),
      .cmp_o     (cmp_v[g]),
      .hit_o     (hit_v[g]),
      .stat_o    (stat_v[g]),
      .ien_o     (ien_v[g]),
      .irq_o     (irq_v[g])
    );
  end

  mtw_watchdog u_wdog (
    .clk     (clk),
    .rst     (rst),
    .arm_i   (wr_en && (bus_waddr == IDX_WEN) && bus_wdata[0]),
    .hit_i   (hit_v[WDOG_CH]),
    .armed_o (wdog_armed),
    .pulse_o (wdog_pulse)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_waddr == WADDR_W'(i)) rd_mux = cmp_v[i];
    end
    if (bus_waddr == IDX_CNT)  rd_mux = cnt;
    if (bus_waddr == IDX_STAT) rd_mux[NUM_CH-1:0] = stat_v;
    if (bus_waddr == IDX_WEN)  rd_mux[0] = wdog_armed;
    if (bus_waddr == IDX_IEN)  rd_mux[NUM_CH-1:0] = ien_v;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata  = rdata_q;
  assign irq_o      = irq_v;
  assign wdog_rst_o = wdog_pulse;

  // R10: unused indices read as zero
  a_r10_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (bus_waddr > IDX_LAST)) |=> (bus_rdata == '0));

  // R1: a counter read returns the value seen in the request cycle
  a_r1_counter_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (bus_waddr == IDX_CNT)) |=> (bus_rdata == $past(cnt)));

endmodule

// File: tb/match_timer_wdog_tb_top.sv
module match_timer_wdog_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned NC = 4;

  localparam logic [AW-1:0] A_CNT  = 4'd4;
  localparam logic [AW-1:0] A_STAT = 4'd5;
  localparam logic [AW-1:0] A_WEN  = 4'd6;
  localparam logic [AW-1:0] A_IEN  = 4'd7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_waddr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NC-1:0] irq_o;
  logic          wdog_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  match_timer_wdog #(.DATA_W(DW), .WADDR_W(AW), .NUM_CH(NC), .WDOG_CH(3)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model, built from the requirements ----------
  logic [DW-1:0] m_cnt = '0;
  logic [DW-1:0] m_cmp [NC] = '{default: '0};
  logic [NC-1:0] m_stat = '0;
  logic [NC-1:0] m_ien = '0;
  logic          m_wen = 1'b0;
  logic          m_wdog = 1'b0;
  logic [NC-1:0] m_irq = '0;
  logic [DW-1:0] m_rdata = '0;
  logic          m_rd_chk = 1'b0;
  logic [NC-1:0] t_hit;
  logic [NC-1:0] t_clr;

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a < 4'd4)        v = m_cmp[a[1:0]];
    else if (a == A_CNT) v = m_cnt;
    else if (a == A_STAT) v[NC-1:0] = m_stat;
    else if (a == A_WEN) v[0] = m_wen;
    else if (a == A_IEN) v[NC-1:0] = m_ien;
    return v;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt <= '0; m_stat <= '0; m_ien <= '0; m_wen <= 1'b0;
      m_wdog <= 1'b0; m_irq <= '0; m_rdata <= '0; m_rd_chk <= 1'b1;
      for (int i = 0; i < NC; i++) m_cmp[i] <= '0;
    end else begin
      for (int i = 0; i < NC; i++) t_hit[i] = (m_cnt == m_cmp[i]);
      t_clr = (bus_sel && bus_wr && bus_waddr == A_STAT) ? bus_wdata[NC-1:0] : '0;
      m_rd_chk <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) m_rdata <= model_read(bus_waddr);
      m_cnt <= (bus_sel && bus_wr && bus_waddr == A_CNT) ? bus_wdata : m_cnt + 32'd1;
      for (int i = 0; i < NC; i++)
        if (bus_sel && bus_wr && bus_waddr == AW'(i)) m_cmp[i] <= bus_wdata;
      m_stat <= t_hit | (m_stat & ~t_clr);
      if (bus_sel && bus_wr && bus_waddr == A_IEN) begin
        m_ien <= bus_wdata[NC-1:0];
        m_irq <= (t_hit | (m_stat & ~t_clr)) & bus_wdata[NC-1:0];
      end else begin
        m_irq <= (t_hit | (m_stat & ~t_clr)) & m_ien;
      end
      if (bus_sel && bus_wr && bus_waddr == A_WEN && bus_wdata[0]) m_wen <= 1'b1;
      m_wdog <= m_wen & t_hit[3];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      check(irq_o == m_irq, "R6 irq level", DW'(irq_o), DW'(m_irq));
      check(wdog_rst_o == m_wdog, "R8 watchdog pulse", DW'(wdog_rst_o), DW'(m_wdog));
      if (m_rd_chk)
        check(bus_rdata == m_rdata, "R1 read data", bus_rdata, m_rdata);
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    logic [DW-1:0] base;
    int pulses;
    void'($urandom(32'd24681));

    // R9: state during reset
    repeat (4) @(negedge clk);
    check(irq_o == '0, "R9 reset irq", DW'(irq_o), '0);
    check(wdog_rst_o == 1'b0, "R9 reset wdog", DW'(wdog_rst_o), '0);
    check(bus_rdata == '0, "R9 reset rdata", bus_rdata, '0);
    rst = 1'b0;

    bus_read(A_IEN, rd);  check(rd == '0, "R9 enables after reset", rd, '0);
    bus_read(A_WEN, rd);  check(rd == '0, "R9 arm after reset", rd, '0);
    bus_read(4'd2, rd);   check(rd == '0, "R9 compare after reset", rd, '0);

    // R1: compare registers read back
    for (int i = 0; i < NC; i++) bus_write(AW'(i), 32'h5A5A_0000 + 32'(i * 17));
    for (int i = 0; i < NC; i++) begin
      bus_read(AW'(i), rd);
      check(rd == 32'h5A5A_0000 + 32'(i * 17), "R1 compare readback", rd,
            32'h5A5A_0000 + 32'(i * 17));
    end

    // R10: unused index
    bus_write(4'd9, 32'hDEAD_BEEF);
    bus_read(4'd9, rd);  check(rd == '0, "R10 unused read", rd, '0);
    bus_read(4'd1, rd);  check(rd == 32'h5A5A_0011, "R10 write ignored", rd, 32'h5A5A_0011);

    // R3 load, R2 wrap
    bus_write(A_CNT, 32'hFFFF_FFFF);
    bus_read(A_CNT, rd); check(rd == 32'hFFFF_FFFF, "R3 counter load", rd, 32'hFFFF_FFFF);
    bus_read(A_CNT, rd); check(rd == 32'h0, "R2 counter wrap", rd, 32'h0);
    bus_read(A_CNT, rd); check(rd == 32'h1, "R2 counter step", rd, 32'h1);

    // R4: passed compare value gives no event
    bus_write(A_CNT, 32'd1000);
    bus_write(4'd1, 32'd990);
    bus_write(A_STAT, 32'hF);
    idle(30);
    bus_read(A_STAT, rd); check(rd == '0, "R4 passed value no hit", rd, '0);

    // R4/R6: exact hit on channel 2
    bus_write(A_IEN, 32'h4);
    base = m_cnt;
    bus_write(4'd2, base + 32'd10);
    idle(15);
    bus_read(A_STAT, rd); check(rd == 32'h4, "R4 hit sets flag", rd, 32'h4);
    check(irq_o == 4'h4, "R6 irq asserted", DW'(irq_o), 32'h4);

    // R6: disabling keeps flag
    bus_write(A_IEN, 32'h0);
    check(irq_o == 4'h0, "R6 irq removed", DW'(irq_o), 32'h0);
    bus_read(A_STAT, rd); check(rd == 32'h4, "R6 flag kept", rd, 32'h4);

    // R5: write-one-to-clear
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, rd); check(rd == 32'h4, "R5 zero write no effect", rd, 32'h4);
    bus_write(A_STAT, 32'h4);
    bus_read(A_STAT, rd); check(rd == 32'h0, "R5 one write clears", rd, 32'h0);

    // R5: set wins over clear in the same cycle
    bus_write(A_CNT, 32'd3000);
    bus_write(4'd0, 32'd3005);
    while (m_cnt != 32'd3005) @(negedge clk);
    bus_write(A_STAT, 32'h1);
    bus_read(A_STAT, rd); check(rd == 32'h1, "R5 set wins", rd, 32'h1);

    // R7/R8: watchdog
    bus_write(A_WEN, 32'h1);
    bus_read(A_WEN, rd); check(rd == 32'h1, "R7 arm set", rd, 32'h1);
    base = m_cnt;
    bus_write(4'd3, base + 32'd8);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (wdog_rst_o) pulses++;
    end
    check(pulses == 1, "R8 single pulse", DW'(pulses), 32'd1);
    bus_write(A_WEN, 32'h0);
    bus_read(A_WEN, rd); check(rd == 32'h1, "R7 arm sticky", rd, 32'h1);

    // Constrained random traffic checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      int unsigned k;
      k = $urandom % 10;
      bus_sel = 1'b1;
      bus_wr = 1'b1;
      case (k)
        0, 1: begin bus_waddr = AW'($urandom % 4); bus_wdata = m_cnt + 32'(2 + $urandom % 12); end
        2: begin bus_waddr = A_IEN; bus_wdata = 32'($urandom % 16); end
        3: begin bus_waddr = A_STAT; bus_wdata = 32'($urandom % 16); end
        4: begin
             bus_waddr = A_CNT;
             bus_wdata = ($urandom % 2 == 0) ? 32'hFFFF_FFF0 + 32'($urandom % 8) : $urandom;
           end
        5: begin bus_waddr = AW'(8 + $urandom % 8); bus_wdata = $urandom; end
        6, 7: begin bus_wr = 1'b0; bus_waddr = AW'($urandom % 16); end
        8: begin bus_waddr = A_WEN; bus_wdata = 32'($urandom % 2); end
        default: bus_sel = 1'b0;
      endcase
      @(negedge clk);
    end
    bus_sel = 1'b0;
    bus_wr = 1'b0;
    idle(3);
    finish_run();
  end

endmodule